// File: doc/BRIEF.md
# Two-Wire Wiper Register Slave

This block is a slave on a two-wire serial bus (I2C-compatible, standard and fast mode up to 400 kHz) that owns a 6-bit wiper code for a digitally set resistor. Both bus lines are brought into the system clock domain through two flops and then edge-detected. The system clock must run at least 16 times faster than the bus clock. The block recognises START and STOP conditions, decodes a 7-bit address and acknowledges each byte it accepts by pulling SDA low.

A write transfer carries three kinds of byte, in this order: the address byte, an instruction byte and one or more data bytes. Every data byte loads the wiper, until the wiper is permanently set. The top bit of the instruction byte requests a one-time permanent setting. When that bit is acknowledged, the block raises a one-cycle request that carries the current wiper code. From then on the wiper is frozen.

A read transfer returns one byte. Its two top bits are status bits supplied from outside the block, and its lower six bits are the wiper code. SDA is driven only as an open-drain low request, so the pad logic outside the block does the actual driving.

Top module: `i2c_wiper_slave`

## Requirements
- R1: After reset the wiper code is 0x20 (midscale), SDA is released, and the write strobe and program request are low.
- R2: An address byte whose upper seven bits equal binary 010110 followed by `addr_sel_i` is acknowledged, and its LSB selects read (1) or write (0). Any other address gets no acknowledge, and SDA stays released and the wiper unchanged until the next START.
- R3: In a write, the byte after the instruction byte is acknowledged. Its low six bits (bits 5..0) become the wiper code, and `wiper_we_o` pulses for exactly one clock. The wiper never changes without that strobe.
- R4: Each further data byte in the same write, with no new START, is acknowledged and updates the wiper again.
- R5: A read returns one byte MSB first. It is laid out as `status_i[1]`, `status_i[0]`, then wiper bits 5..0.
- R6: An instruction byte with bit 7 set, acknowledged before any permanent setting, pulses `prog_req_o` for exactly one clock. In that same cycle `prog_code_o` shows the wiper code held at that time.
- R7: After a program request, data bytes and further instruction bytes with bit 7 set are still acknowledged but have no effect: the wiper holds and no new request is raised.
- R8: A START seen in the middle of a byte abandons that byte and starts address reception again.
- R9: A STOP releases SDA and returns to idle. Bytes clocked after it without a new START are not acknowledged and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel_i | input | 1 | Pin-selected address bit |
| status_i | input | 2 | Validation bits returned in the top of the read byte |
| sda_low_o | output | 1 | 1 pulls SDA low (open drain) |
| wiper_o | output | 6 | Current wiper code |
| wiper_we_o | output | 1 | One-clock strobe when the wiper is loaded |
| prog_req_o | output | 1 | One-clock permanent-setting request |
| prog_code_o | output | 6 | Wiper code captured with the request |

## Verification
The permanent-setting request and the lock that freezes the wiper take effect in the same clock, on the acknowledge of a T=1 instruction byte. The bench provokes this by following that instruction with data bytes in the same write. The test passes only if the request carries the wiper code from before those data bytes and the wiper does not move after it. A second transfer with T=1 then shows that no further request or load happens, while the read byte still reflects the external status bits together with the frozen code.

// File: rtl/wiper_slave_pkg.sv
package wiper_slave_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_RX,
        PH_ACK,
        PH_TX
    } phase_t;

    typedef enum logic [1:0] {
        BK_ADDR,
        BK_INSTR,
        BK_DATA
    } byte_kind_t;

    localparam logic [5:0] DEV_ADDR_HI = 6'b010110;

endpackage

// File: rtl/bus_line_sync.sv
module bus_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], line_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~prev_q;
    assign fall_o  = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/i2c_wiper_slave.sv
module i2c_wiper_slave
    import wiper_slave_pkg::*;
#(
    parameter int WIPER_W = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    input  logic                 addr_sel_i,
    input  logic [1:0]           status_i,
    output logic                 sda_low_o,
    output logic [WIPER_W-1:0]   wiper_o,
    output logic                 wiper_we_o,
    output logic                 prog_req_o,
    output logic [WIPER_W-1:0]   prog_code_o
);

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [WIPER_W-1:0] MID_CODE = WIPER_W'(1) << (WIPER_W - 1);
    localparam logic [CNT_W-1:0]   LAST_BIT = CNT_W'(BYTE_W);

    typedef struct packed {
        phase_t              phase;
        byte_kind_t          kind;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-1:0]   shreg;
        logic                rd;
        logic                sda_low;
        logic [WIPER_W-1:0]  wiper;
        logic                locked;
        logic                we;
        logic                prog;
        logic [WIPER_W-1:0]  prog_code;
    } regs_t;

    regs_t q, d;

    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    logic start_det, stop_det;

    logic [1:0] line_in;
    logic [1:0] lvl_v, rise_v, fall_v;
    assign line_in = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        bus_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_i  (line_in[g]),
            .level_o (lvl_v[g]),
            .rise_o  (rise_v[g]),
            .fall_o  (fall_v[g])
        );
    end

    assign scl_lvl  = lvl_v[0];
    assign scl_rise = rise_v[0];
    assign scl_fall = fall_v[0];
    assign sda_lvl  = lvl_v[1];
    assign sda_rise = rise_v[1];
    assign sda_fall = fall_v[1];

    assign start_det = scl_lvl & ~scl_rise & sda_fall;
    assign stop_det  = scl_lvl & ~scl_rise & sda_rise;

    always_comb begin
        d      = q;
        d.we   = 1'b0;
        d.prog = 1'b0;
        if (start_det) begin
            d.phase   = PH_RX;
            d.kind    = BK_ADDR;
            d.cnt     = '0;
            d.sda_low = 1'b0;
        end else if (stop_det) begin
            d.phase   = PH_IDLE;
            d.sda_low = 1'b0;
        end else begin
            unique case (q.phase)
                PH_RX: begin
                    if (scl_rise && q.cnt != LAST_BIT) begin
                        d.shreg = {q.shreg[BYTE_W-2:0], sda_lvl};
                        d.cnt   = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == LAST_BIT) begin
                        d.phase   = PH_ACK;
                        d.sda_low = 1'b1;
                        d.rd      = 1'b0;
                        unique case (q.kind)
                            BK_ADDR: begin
                                if (q.shreg[BYTE_W-1:1] == {DEV_ADDR_HI, addr_sel_i}) begin
                                    d.rd = q.shreg[0];
                                end else begin
                                    d.phase   = PH_IDLE;
                                    d.sda_low = 1'b0;
                                end
                            end
                            BK_INSTR: begin
                                if (q.shreg[BYTE_W-1] && !q.locked) begin
                                    d.prog      = 1'b1;
                                    d.locked    = 1'b1;
                                    d.prog_code = q.wiper;
                                end
                            end
                            default: begin
                                if (!q.locked) begin
                                    d.wiper = q.shreg[WIPER_W-1:0];
                                    d.we    = 1'b1;
                                end
                            end
                        endcase
                    end
                end
                PH_ACK: begin
                    if (scl_fall) begin
                        if (q.rd) begin
                            d.phase   = PH_TX;
                            d.shreg   = {status_i, q.wiper};
                            d.sda_low = ~status_i[1];
                            d.cnt     = CNT_W'(1);
                        end else begin
                            d.phase   = PH_RX;
                            d.sda_low = 1'b0;
                            d.cnt     = '0;
                            d.kind    = (q.kind == BK_ADDR) ? BK_INSTR : BK_DATA;
                        end
                    end
                end
                PH_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == LAST_BIT) begin
                            d.phase   = PH_IDLE;
                            d.sda_low = 1'b0;
                        end else begin
                            d.shreg   = {q.shreg[BYTE_W-2:0], 1'b0};
                            d.sda_low = ~q.shreg[BYTE_W-2];
                            d.cnt     = q.cnt + 1'b1;
                        end
                    end
                end
                default: d.sda_low = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.phase     <= PH_IDLE;
            q.kind      <= BK_ADDR;
            q.wiper     <= MID_CODE;
        end else begin
            q <= d;
        end
    end

    assign sda_low_o   = q.sda_low;
    assign wiper_o     = q.wiper;
    assign wiper_we_o  = q.we;
    assign prog_req_o  = q.prog;
    assign prog_code_o = q.prog_code;

    AST_SDA_ONLY_ACK_TX: assert property (@(posedge clk) disable iff (!rst_n)
        sda_low_o |-> (q.phase == PH_ACK || q.phase == PH_TX)) else $error("sda driven outside ack/tx"); // R2

    AST_WIPER_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (wiper_o != $past(wiper_o)) |-> wiper_we_o) else $error("wiper moved without strobe"); // R3

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wiper_we_o |=> !wiper_we_o) else $error("write strobe too long"); // R3

    AST_PROG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req_o |=> (!prog_req_o && q.locked)) else $error("program request misbehaved"); // R6

    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        q.locked |=> ($stable(wiper_o) && !prog_req_o)) else $error("locked wiper changed"); // R7

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_low_o) else $error("sda held after stop"); // R9

endmodule

// File: tb/sim_i2c_wiper_slave.sv
`timescale 1ns/1ps
module sim_i2c_wiper_slave;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_tb = 1'b1;
    logic       addr_sel = 1'b1;
    logic [1:0] status = 2'b00;
    logic       sda_low;
    logic [5:0] wiper;
    logic       wiper_we;
    logic       prog_req;
    logic [5:0] prog_code;
    logic       sda_bus;

    int tests = 0;
    int fails = 0;
    int we_cnt = 0;
    int prog_cnt = 0;
    logic [5:0] prog_seen = '0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign sda_bus = sda_tb & ~sda_low;

    i2c_wiper_slave u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_bus),
        .addr_sel_i (addr_sel),
        .status_i   (status),
        .sda_low_o  (sda_low),
        .wiper_o    (wiper),
        .wiper_we_o (wiper_we),
        .prog_req_o (prog_req),
        .prog_code_o(prog_code)
    );

    always @(posedge clk) begin
        if (wiper_we) we_cnt <= we_cnt + 1;
        if (prog_req) begin
            prog_cnt  <= prog_cnt + 1;
            prog_seen <= prog_code;
        end
    end

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        scl = 1'b0; waitc(5);
        sda_tb = 1'b1; waitc(5);
        scl = 1'b1; waitc(5);
        sda_tb = 1'b0; waitc(10);
    endtask

    task automatic bus_stop();
        scl = 1'b0; waitc(7);
        sda_tb = 1'b0; waitc(5);
        scl = 1'b1; waitc(5);
        sda_tb = 1'b1; waitc(10);
    endtask

    task automatic put_bit(input logic b);
        scl = 1'b0; waitc(7);
        sda_tb = b; waitc(5);
        scl = 1'b1; waitc(10);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        scl = 1'b0; waitc(7);
        sda_tb = 1'b1; waitc(5);
        scl = 1'b1; waitc(5);
        acked = ~sda_bus;
        waitc(5);
    endtask

    task automatic recv_byte(output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            scl = 1'b0; waitc(7);
            sda_tb = 1'b1; waitc(5);
            scl = 1'b1; waitc(5);
            b[i] = sda_bus;
            waitc(5);
        end
        put_bit(1'b1);
    endtask

    task automatic t_reset();
        check("R1 wiper", wiper, 6'h20);
        check("R1 sda", sda_low, 0);
        check("R1 strobes", {wiper_we, prog_req}, 0);
    endtask

    task automatic t_write();
        logic a;
        int w0;
        w0 = we_cnt;
        bus_start();
        send_byte(8'h5A, a); check("R2 addr ack", a, 1);
        send_byte(8'h00, a); check("R3 instr ack", a, 1);
        send_byte(8'hC5, a); check("R3 data ack", a, 1);
        waitc(4);
        check("R3 wiper", wiper, 6'h05);
        check("R3 strobe count", we_cnt - w0, 1);
        send_byte(8'h11, a); waitc(4);
        check("R4 wiper 2nd", wiper, 6'h11);
        send_byte(8'h3F, a); waitc(4);
        check("R4 wiper 3rd", wiper, 6'h3F);
        check("R4 strobe count", we_cnt - w0, 3);
        bus_stop();
    endtask

    task automatic t_mismatch();
        logic a;
        bus_start();
        send_byte(8'h58, a); check("R2 mismatch nack", a, 0);
        send_byte(8'h00, a); check("R2 mismatch instr nack", a, 0);
        send_byte(8'h07, a); check("R2 mismatch data nack", a, 0);
        waitc(4);
        check("R2 wiper held", wiper, 6'h3F);
        bus_stop();
    endtask

    task automatic t_read(input logic [1:0] st, input logic [7:0] exp);
        logic a;
        logic [7:0] b;
        status = st;
        bus_start();
        send_byte(8'h5B, a); check("R5 read addr ack", a, 1);
        recv_byte(b);
        check("R5 read byte", b, exp);
        bus_stop();
    endtask

    task automatic t_abort();
        logic a;
        bus_start();
        send_byte(8'h5A, a);
        send_byte(8'h00, a);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_start();
        send_byte(8'h5A, a); check("R8 restart addr ack", a, 1);
        send_byte(8'h00, a);
        send_byte(8'h2A, a); waitc(4);
        check("R8 wiper after restart", wiper, 6'h2A);
        bus_stop();
    endtask

    task automatic t_stop_idle();
        logic a;
        bus_start();
        send_byte(8'h5A, a);
        send_byte(8'h00, a);
        bus_stop();
        check("R9 sda released", sda_low, 0);
        send_byte(8'h5A, a); check("R9 no ack after stop", a, 0);
        send_byte(8'h01, a);
        waitc(4);
        check("R9 wiper held", wiper, 6'h2A);
    endtask

    task automatic t_program();
        logic a;
        int w0;
        w0 = we_cnt;
        bus_start();
        send_byte(8'h5A, a);
        send_byte(8'h80, a); check("R6 prog instr ack", a, 1);
        waitc(4);
        check("R6 one request", prog_cnt, 1);
        check("R6 request code", prog_seen, 6'h2A);
        send_byte(8'h15, a); check("R7 data still acked", a, 1);
        waitc(4);
        check("R7 wiper frozen", wiper, 6'h2A);
        bus_stop();
        bus_start();
        send_byte(8'h5A, a);
        send_byte(8'h80, a);
        send_byte(8'h01, a);
        waitc(4);
        check("R7 no second request", prog_cnt, 1);
        check("R7 no strobe", we_cnt - w0, 0);
        check("R7 wiper frozen 2", wiper, 6'h2A);
        bus_stop();
    endtask

    initial begin
        waitc(5);
        rst_n = 1'b1;
        waitc(5);
        t_reset();
        t_write();
        t_mismatch();
        t_read(2'b01, 8'h7F);
        t_abort();
        t_stop_idle();
        t_program();
        t_read(2'b11, 8'hEA);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule